// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns a segmented virtual address into a physical address. The top bits of the virtual address pick one of a small number of segment descriptors. The remaining bits are an offset into that segment. Each descriptor holds its own base, its own limit, a set of access rights and a valid flag. Descriptors are loaded one at a time through a single write port.

For each request the unit reads the selected descriptor and runs three checks. It then returns either `base + offset` or a fault code naming the first check that failed. The result is registered and appears one clock after the request strobe. Two descriptors may share the same base and limit while granting different rights, so one region can be mapped with different permissions for different users.

Top module: `seg_xlate`

## Requirements
- R1: The virtual address `req_vaddr[31:29]` is the segment number and `req_vaddr[28:0]` is the offset. A request strobed on one rising edge produces `rsp_valid` high for exactly the following cycle, with the result fields updated at that same edge.
- R2: A write with `tw_en` high stores base, limit, rights and valid flag into descriptor `tw_idx`, and the other descriptors are left unchanged. A request sampled on the same edge as the write sees the old descriptor. A request on the next edge sees the new one.
- R3: When no fault occurs, `rsp_paddr` is `base + offset` taken modulo 2^32, and `rsp_fault` is 0 with `rsp_code` 0. For example, base 640000 with limit 200000 maps offsets 0 to 199999 onto 640000 to 839999.
- R4: If the offset, zero-extended, is not strictly below the limit, the response is `rsp_fault`=1 with `rsp_code`=2 (bounds) and `rsp_paddr`=0. A limit of 0 therefore rejects every offset.
- R5: The rights field is bit0 = read, bit1 = write, bit2 = execute. The access type `req_acc` is 0 for read, 1 for write, 2 for execute and 3 reserved. A reserved access, or an access whose right bit is clear, gives `rsp_fault`=1, `rsp_code`=3 (permission) and `rsp_paddr`=0.
- R6: An access to a descriptor whose valid flag is clear gives `rsp_fault`=1, `rsp_code`=1 (segment invalid) and `rsp_paddr`=0. This check takes priority over the bounds and permission checks.
- R7: When an access is both out of bounds and not permitted, the bounds code (2) is reported.
- R8: After reset every descriptor is invalid, and `rsp_valid`, `rsp_paddr`, `rsp_fault` and `rsp_code` are all 0.
- R9: In a cycle with no request, `rsp_valid` is low and `rsp_paddr`, `rsp_fault` and `rsp_code` keep their previous values.
- R10: Two descriptors holding the same base and limit with different rights give independent permission results for the same offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 32 | Virtual address: segment number and offset |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 reserved |
| tw_en | input | 1 | Descriptor write enable |
| tw_idx | input | 3 | Descriptor to write |
| tw_base | input | 32 | Base to store |
| tw_limit | input | 32 | Limit to store |
| tw_perm | input | 3 | Rights to store: bit0 read, bit1 write, bit2 execute |
| tw_valid | input | 1 | Valid flag to store |
| rsp_valid | output | 1 | Result strobe, one cycle after a request |
| rsp_paddr | output | 32 | Physical address, 0 on a fault |
| rsp_fault | output | 1 | Fault flag |
| rsp_code | output | 2 | 0 none, 1 segment invalid, 2 bounds, 3 permission |

## Verification
The assertions take for granted that all inputs are driven to known values after reset. They also assume `req_vaddr` and `req_acc` stay steady while `req_valid` is sampled. The response checks further assume that the descriptor read on a request cycle belongs to the segment addressed on that cycle. The stimulus meets these conditions by changing every input only on the falling clock edge. It draws segment numbers, rights and access codes from the full encoded ranges, including the reserved access code. Offsets are often placed within a few counts of the limit, so that both sides of the bounds comparison are reached.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_t;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_SEGINV = 2'd1,
    FLT_BOUNDS = 2'd2,
    FLT_PERM   = 2'd3
  } flt_t;

  localparam int PERM_W = 3;

endpackage

// File: rtl/seg_table.sv
module seg_table #(
  parameter int SEG_W  = 3,
  parameter int ADDR_W = 32,
  localparam int NSEG  = 1 << SEG_W
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              wr_en,
  input  logic [SEG_W-1:0]                  wr_idx,
  input  logic [ADDR_W-1:0]                 wr_base,
  input  logic [ADDR_W-1:0]                 wr_limit,
  input  logic [seg_xlate_pkg::PERM_W-1:0]  wr_perm,
  input  logic                              wr_valid,
  input  logic [SEG_W-1:0]                  rd_idx,
  output logic [ADDR_W-1:0]                 rd_base,
  output logic [ADDR_W-1:0]                 rd_limit,
  output logic [seg_xlate_pkg::PERM_W-1:0]  rd_perm,
  output logic                              rd_valid
);

  // Descriptor storage: no reset, so it can map onto distributed RAM.
  logic [ADDR_W-1:0]                base_mem  [NSEG];
  logic [ADDR_W-1:0]                limit_mem [NSEG];
  logic [seg_xlate_pkg::PERM_W-1:0] perm_mem  [NSEG];
  // Valid flags are flops with reset so that every descriptor starts invalid.
  logic [NSEG-1:0]                  valid_q;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      base_mem[wr_idx]  <= wr_base;
      limit_mem[wr_idx] <= wr_limit;
      perm_mem[wr_idx]  <= wr_perm;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= wr_valid;
    end
  end

  assign rd_base  = base_mem[rd_idx];
  assign rd_limit = limit_mem[rd_idx];
  assign rd_perm  = perm_mem[rd_idx];
  assign rd_valid = valid_q[rd_idx];

  // R2: a write reaches exactly the addressed descriptor on the next edge.
  for (genvar gi = 0; gi < NSEG; gi++) begin : g_entry_chk
    p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_idx == SEG_W'(gi)) |=>
        (base_mem[gi] == $past(wr_base) && limit_mem[gi] == $past(wr_limit) &&
         perm_mem[gi] == $past(wr_perm) && valid_q[gi] == $past(wr_valid)));
    p_other_kept_r2: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_idx != SEG_W'(gi)) |=> $stable(valid_q[gi]));
  end

endmodule

// File: rtl/seg_check.sv
module seg_check #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 29
) (
  input  logic [OFF_W-1:0]                  offset,
  input  logic [1:0]                        acc,
  input  logic [ADDR_W-1:0]                 base,
  input  logic [ADDR_W-1:0]                 limit,
  input  logic [seg_xlate_pkg::PERM_W-1:0]  perm,
  input  logic                              seg_valid,
  output logic [ADDR_W-1:0]                 paddr,
  output logic [1:0]                        code
);
  import seg_xlate_pkg::*;

  logic [ADDR_W-1:0] off_ext;
  logic              in_bounds;
  logic              allowed;
  flt_t              code_e;

  assign off_ext   = ADDR_W'(offset);
  assign in_bounds = off_ext < limit;

  always_comb begin
    unique case (acc_t'(acc))
      ACC_READ:  allowed = perm[0];
      ACC_WRITE: allowed = perm[1];
      ACC_EXEC:  allowed = perm[2];
      default:   allowed = 1'b0;
    endcase
  end

  // Priority: invalid segment, then bounds, then rights.
  always_comb begin
    if (!seg_valid)      code_e = FLT_SEGINV;
    else if (!in_bounds) code_e = FLT_BOUNDS;
    else if (!allowed)   code_e = FLT_PERM;
    else                 code_e = FLT_NONE;
  end

  assign code  = code_e;
  assign paddr = (code_e == FLT_NONE) ? base + off_ext : '0;

  // A granted access must be inside the segment and carry the right.
  always_comb begin
    if (code_e == FLT_NONE) begin
      p_grant_in_bounds_r4: assert (seg_valid && (off_ext < limit));
      p_grant_permitted_r5: assert (acc != 2'd3 && perm[acc] == 1'b1);
    end
  end

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int VA_W   = 32,
  parameter int SEG_W  = 3,
  parameter int ADDR_W = 32,
  localparam int OFF_W = VA_W - SEG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [1:0]        req_acc,
  input  logic              tw_en,
  input  logic [SEG_W-1:0]  tw_idx,
  input  logic [ADDR_W-1:0] tw_base,
  input  logic [ADDR_W-1:0] tw_limit,
  input  logic [2:0]        tw_perm,
  input  logic              tw_valid,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic              rsp_fault,
  output logic [1:0]        rsp_code
);
  import seg_xlate_pkg::*;

  logic [SEG_W-1:0]  seg_num;
  logic [OFF_W-1:0]  seg_off;
  logic [ADDR_W-1:0] d_base, d_limit, x_paddr;
  logic [PERM_W-1:0] d_perm;
  logic              d_valid;
  logic [1:0]        x_code;

  assign seg_num = req_vaddr[VA_W-1 -: SEG_W];
  assign seg_off = req_vaddr[OFF_W-1:0];

  seg_table #(.SEG_W(SEG_W), .ADDR_W(ADDR_W)) u_table (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (tw_en),
    .wr_idx   (tw_idx),
    .wr_base  (tw_base),
    .wr_limit (tw_limit),
    .wr_perm  (tw_perm),
    .wr_valid (tw_valid),
    .rd_idx   (seg_num),
    .rd_base  (d_base),
    .rd_limit (d_limit),
    .rd_perm  (d_perm),
    .rd_valid (d_valid)
  );

  seg_check #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_check (
    .offset    (seg_off),
    .acc       (req_acc),
    .base      (d_base),
    .limit     (d_limit),
    .perm      (d_perm),
    .seg_valid (d_valid),
    .paddr     (x_paddr),
    .code      (x_code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_fault <= 1'b0;
      rsp_code  <= FLT_NONE;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_paddr <= x_paddr;
        rsp_fault <= (x_code != FLT_NONE);
        rsp_code  <= x_code;
      end
    end
  end

  p_rsp_after_req_r1: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  p_quiet_no_req_r9: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  p_hold_no_req_r9: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> ($stable(rsp_paddr) && $stable(rsp_code) && $stable(rsp_fault)));
  p_fault_zero_addr_r4: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> rsp_paddr == '0);
  p_invalid_first_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !d_valid) |=> (rsp_code == FLT_SEGINV));
  p_bounds_before_perm_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && d_valid && ADDR_W'(seg_off) >= d_limit) |=> (rsp_code == FLT_BOUNDS));

endmodule

// File: tb/sim_seg_xlate.sv
`timescale 1ns/1ps
module sim_seg_xlate;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_acc = '0;
  logic        tw_en = 1'b0;
  logic [2:0]  tw_idx = '0;
  logic [31:0] tw_base = '0;
  logic [31:0] tw_limit = '0;
  logic [2:0]  tw_perm = '0;
  logic        tw_valid = 1'b0;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic        rsp_fault;
  logic [1:0]  rsp_code;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] m_base [8];
  logic [31:0] m_lim  [8];
  logic [2:0]  m_perm [8];
  logic        m_val  [8];

  always #2.5 clk = ~clk;

  seg_xlate u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_acc(req_acc), .tw_en(tw_en), .tw_idx(tw_idx), .tw_base(tw_base),
    .tw_limit(tw_limit), .tw_perm(tw_perm), .tw_valid(tw_valid),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .rsp_code(rsp_code)
  );

  // Expected {code, paddr} from the requirements.
  function automatic logic [33:0] expect_of(logic [31:0] va, logic [1:0] acc);
    logic [2:0]  s;
    logic [31:0] off;
    logic        ok;
    s   = va[31:29];
    off = {3'b000, va[28:0]};
    ok  = (acc == 2'd3) ? 1'b0 : m_perm[s][acc];
    if (!m_val[s])          return {2'd1, 32'd0};
    if (!(off < m_lim[s]))  return {2'd2, 32'd0};
    if (!ok)                return {2'd3, 32'd0};
    return {2'd0, m_base[s] + off};
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_write(logic [2:0] idx, logic [31:0] b, logic [31:0] l,
                          logic [2:0] p, logic v);
    @(negedge clk);
    tw_en = 1'b1; tw_idx = idx; tw_base = b; tw_limit = l; tw_perm = p; tw_valid = v;
    @(negedge clk);
    tw_en = 1'b0;
    m_base[idx] = b; m_lim[idx] = l; m_perm[idx] = p; m_val[idx] = v;
  endtask

  task automatic do_req(string req, logic [31:0] va, logic [1:0] acc);
    logic [33:0] e;
    e = expect_of(va, acc);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_acc = acc;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req, "valid", {31'd0, rsp_valid}, 32'd1);
    chk(req, "code",  {30'd0, rsp_code}, {30'd0, e[33:32]});
    chk(req, "fault", {31'd0, rsp_fault}, {31'd0, e[33:32] != 2'd0});
    chk(req, "paddr", rsp_paddr, e[31:0]);
  endtask

  // Write and request on the same edge: the request must see the old descriptor.
  task automatic do_write_req(logic [2:0] idx, logic [31:0] b, logic [31:0] l,
                              logic [2:0] p, logic v, logic [31:0] va, logic [1:0] acc);
    logic [33:0] e;
    e = expect_of(va, acc);
    @(negedge clk);
    tw_en = 1'b1; tw_idx = idx; tw_base = b; tw_limit = l; tw_perm = p; tw_valid = v;
    req_valid = 1'b1; req_vaddr = va; req_acc = acc;
    @(negedge clk);
    tw_en = 1'b0; req_valid = 1'b0;
    m_base[idx] = b; m_lim[idx] = l; m_perm[idx] = p; m_val[idx] = v;
    chk("R2", "same-edge code",  {30'd0, rsp_code}, {30'd0, e[33:32]});
    chk("R2", "same-edge paddr", rsp_paddr, e[31:0]);
  endtask

  task automatic do_idle();
    logic [31:0] pa;
    logic [1:0]  cd;
    logic        ft;
    pa = rsp_paddr; cd = rsp_code; ft = rsp_fault;
    @(negedge clk);
    chk("R9", "idle valid", {31'd0, rsp_valid}, 32'd0);
    chk("R9", "idle paddr", rsp_paddr, pa);
    chk("R9", "idle code",  {30'd0, rsp_code}, {30'd0, cd});
    chk("R9", "idle fault", {31'd0, rsp_fault}, {31'd0, ft});
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) begin
      m_base[i] = '0; m_lim[i] = '0; m_perm[i] = '0; m_val[i] = 1'b0;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R8: reset state
    chk("R8", "rst valid", {31'd0, rsp_valid}, 32'd0);
    chk("R8", "rst paddr", rsp_paddr, 32'd0);
    chk("R8", "rst fault", {31'd0, rsp_fault}, 32'd0);
    chk("R8", "rst code",  {30'd0, rsp_code}, 32'd0);
    for (int s = 0; s < 8; s++) do_req("R8", {s[2:0], 29'd4}, 2'd0);

    // R3/R4/R5/R7: base 640000 limit 200000, read+write only
    do_write(3'd2, 32'd640000, 32'd200000, 3'b011, 1'b1);
    do_req("R3", {3'd2, 29'd0}, 2'd0);
    do_req("R3", {3'd2, 29'd199999}, 2'd1);
    do_req("R4", {3'd2, 29'd200000}, 2'd0);
    do_req("R5", {3'd2, 29'd5}, 2'd2);
    do_req("R5", {3'd2, 29'd5}, 2'd3);
    do_req("R7", {3'd2, 29'd200000}, 2'd2);
    do_idle();
    // R10: alias with execute only
    do_write(3'd3, 32'd640000, 32'd200000, 3'b100, 1'b1);
    do_req("R10", {3'd3, 29'd77}, 2'd0);
    do_req("R10", {3'd3, 29'd77}, 2'd2);
    do_req("R10", {3'd2, 29'd77}, 2'd0);
    // R3 wrap, R4 zero limit, R1 field split with full offset
    do_write(3'd4, 32'hFFFF_FFF0, 32'h100, 3'b111, 1'b1);
    do_req("R3", {3'd4, 29'h20}, 2'd1);
    do_write(3'd6, 32'h1234, 32'd0, 3'b111, 1'b1);
    do_req("R4", {3'd6, 29'd0}, 2'd0);
    do_write(3'd7, 32'h1000, 32'hFFFF_FFFF, 3'b001, 1'b1);
    do_req("R1", {3'd7, 29'h1FFF_FFFF}, 2'd0);
    do_req("R1", {3'd7, 29'd0}, 2'd0);
    // R2: same-edge write is not seen, next request is
    do_write_req(3'd5, 32'h8000, 32'h40, 3'b111, 1'b1, {3'd5, 29'd3}, 2'd0);
    do_req("R2", {3'd5, 29'd3}, 2'd0);
    // R6: invalidate, out-of-bounds offset still reports invalid
    do_write(3'd2, 32'd640000, 32'd200000, 3'b011, 1'b0);
    do_req("R6", {3'd2, 29'd300000}, 2'd2);
    do_idle();

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      int unsigned r;
      logic [2:0]  s;
      logic [28:0] off;
      r = $urandom % 10;
      s = 3'($urandom);
      if (r < 2) begin
        do_write(s, $urandom, $urandom % 32'h4000_0000, 3'($urandom),
                 ($urandom % 5) != 0);
      end else if (r == 2) begin
        do_write_req(3'($urandom), $urandom, $urandom % 32'h4000_0000, 3'($urandom),
                     1'b1, {s, 29'($urandom)}, 2'($urandom));
      end else if (r == 3) begin
        do_idle();
      end else begin
        if ($urandom % 2 == 0 && m_lim[s] < 32'h2000_0002)
          off = 29'(m_lim[s] + 32'($urandom % 5) - 32'd2);
        else
          off = 29'($urandom);
        do_req((r < 7) ? "R3" : "R4", {s, off}, 2'($urandom));
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule